// File: doc/BRIEF.md
# Audio Channel Count Converter

This block sits between an audio-side stream and a client-side stream and adapts the number of channels in each frame, once in the playback direction and once in the capture direction. Each direction takes one frame per transfer on a valid/ready input and sends one frame per transfer on a valid/ready output. Every frame carries a channel-count field, and the wanted output channel count is a plain configuration input. When the counts differ, the block reduces stereo to mono, expands mono to stereo, or keeps the leading channels. Each direction has its own reduction mode (left, right or average) and its own expansion mode (zero-fill or duplicate).

The converter adds no latency and holds no data. The input is consumed in the same cycle that its converted frame is accepted downstream, so `in_ready` is simply the downstream `out_ready`, and `out_valid` is the upstream `in_valid`. Under back-pressure the upstream side must hold its frame steady, as the valid/ready rules require. While a frame is stalled, the block freezes the settings it first converted that frame with, so a change to the configuration never alters a frame that is on offer. The new settings take effect from the next frame.

Samples are signed, `SW` bits wide. Channel k of a frame occupies data bits `[k*SW +: SW]`. Up to `MAX_CH` channels fit in a frame.

Top module: `chan_count_conv`

## Requirements
- R1: In each direction, out_valid equals in_valid and in_ready equals out_ready in the same cycle. After reset, with no input valid, both out_valid outputs are low.
- R2: If the input count is 2 or more and the output count is 1, the output channel 0 depends on the 2-bit reduction mode: 0 gives input channel 0, 1 gives input channel 1, 2 gives the average of channels 0 and 1, and 3 behaves as 0. All other output channels are zero. Channel k is data bits [k*SW +: SW].
- R3: The average is floor((a+b)/2) of the signed samples, computed one bit wider, so it never wraps. For example, with SW=4, 7 and 7 give 7, -8 and -8 give -8, and -3 and 0 give -2.
- R4: If the input count is 1 and the output count is 2 or more, output channel 0 is the input sample. Output channel 1 is zero in expansion mode 0 and a copy of the sample in mode 1. All higher channels are zero.
- R5: If the input count equals the output count, the output data equals the input data bit for bit, whatever the modes are.
- R6: For any other pair of counts, output channels below min(in, out) copy the input, and the rest are zero. For example, 4 channels to 2 keeps channels 0 and 1.
- R7: The playback and capture directions use only their own count and mode inputs. Settings on one direction do not change the other.
- R8: While out_valid is high and out_ready is low, the output data and count stay fixed for a held input frame, even if the count or mode inputs change. Changed settings apply from the frame that follows the handshake.
- R9: The output count field equals the configured output count that is in force for the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pb_in_valid | input | 1 | Playback input frame valid (audio side) |
| pb_in_ready | output | 1 | Playback input frame accepted |
| pb_in_data | input | MAX_CH*SW | Playback input samples |
| pb_in_ch | input | CW | Playback input channel count |
| pb_out_valid | output | 1 | Playback output frame valid (client side) |
| pb_out_ready | input | 1 | Playback output frame accepted |
| pb_out_data | output | MAX_CH*SW | Playback output samples |
| pb_out_ch | output | CW | Playback output channel count |
| pb_cfg_out_ch | input | CW | Playback configured output count |
| pb_cfg_reduce | input | 2 | Playback reduction mode |
| pb_cfg_expand | input | 1 | Playback expansion mode |
| cp_in_valid | input | 1 | Capture input frame valid (client side) |
| cp_in_ready | output | 1 | Capture input frame accepted |
| cp_in_data | input | MAX_CH*SW | Capture input samples |
| cp_in_ch | input | CW | Capture input channel count |
| cp_out_valid | output | 1 | Capture output frame valid (audio side) |
| cp_out_ready | input | 1 | Capture output frame accepted |
| cp_out_data | output | MAX_CH*SW | Capture output samples |
| cp_out_ch | output | CW | Capture output channel count |
| cp_cfg_out_ch | input | CW | Capture configured output count |
| cp_cfg_reduce | input | 2 | Capture reduction mode |
| cp_cfg_expand | input | 1 | Capture expansion mode |

## Verification
The bench sweeps every pair of 4-bit samples through all four reduction modes in both directions. An average that truncates toward zero, or that wraps at the extremes, shows up at -3 and 0 or at 7 and 7. Every count pair from 1 to 4 is driven, so a design that misorders the pass, reduce, expand and trim cases, or that leaves stale upper channels in place, gives wrong channels. A stall test changes the mode in the middle of a held frame. A design that uses the live settings would change the offered frame, and a design that never releases the frozen settings would convert the next frame wrongly. The two directions are driven at the same time with different modes to expose any crossed settings.

// File: rtl/chan_count_pkg.sv
package chan_count_pkg;

  typedef enum logic [1:0] {
    RED_LEFT  = 2'd0,
    RED_RIGHT = 2'd1,
    RED_AVG   = 2'd2,
    RED_RSVD  = 2'd3
  } reduce_mode_e;

  typedef enum logic {
    EXP_ZERO = 1'b0,
    EXP_COPY = 1'b1
  } expand_mode_e;

  typedef enum logic [1:0] {
    CONV_PASS   = 2'd0,
    CONV_REDUCE = 2'd1,
    CONV_EXPAND = 2'd2,
    CONV_TRIM   = 2'd3
  } conv_kind_e;

  // Select the conversion from the input and output channel counts.
  function automatic conv_kind_e pick_kind(input int unsigned in_n,
                                           input int unsigned out_n);
    if (in_n == out_n)                return CONV_PASS;
    else if (out_n == 1 && in_n >= 2) return CONV_REDUCE;
    else if (in_n == 1 && out_n >= 2) return CONV_EXPAND;
    else                              return CONV_TRIM;
  endfunction

endpackage

// File: rtl/chan_reduce.sv
module chan_reduce
  import chan_count_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [SW-1:0] left,
  input  logic [SW-1:0] right,
  input  reduce_mode_e  mode,
  output logic [SW-1:0] mono
);

  // One guard bit keeps the sum from wrapping; dropping bit 0 is a floor shift.
  logic signed [SW:0] sum;
  assign sum = $signed({left[SW-1], left}) + $signed({right[SW-1], right});

  always_comb begin
    case (mode)
      RED_RIGHT: mono = right;
      RED_AVG:   mono = sum[SW:1];
      default:   mono = left;
    endcase
  end

endmodule

// File: rtl/chan_expand.sv
module chan_expand
  import chan_count_pkg::*;
#(
  parameter int SW  = 16,
  parameter int NCH = 4
) (
  input  logic [SW-1:0]     mono,
  input  expand_mode_e      mode,
  output logic [NCH*SW-1:0] frame
);

  assign frame[0 +: SW]  = mono;
  assign frame[SW +: SW] = (mode == EXP_COPY) ? mono : '0;

  for (genvar i = 2; i < NCH; i++) begin : g_hi
    assign frame[i*SW +: SW] = '0;
  end

endmodule

// File: rtl/chan_trim.sv
module chan_trim #(
  parameter int SW  = 16,
  parameter int NCH = 4,
  parameter int CW  = 3
) (
  input  logic [NCH*SW-1:0] din,
  input  logic [CW-1:0]     keep,
  output logic [NCH*SW-1:0] dout
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [CW-1:0] IDX = CW'(i);
    assign dout[i*SW +: SW] = (IDX < keep) ? din[i*SW +: SW] : '0;
  end

endmodule

// File: rtl/chan_count_lane.sv
module chan_count_lane
  import chan_count_pkg::*;
#(
  parameter int SW  = 16,
  parameter int NCH = 4,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*SW-1:0] in_data,
  input  logic [CW-1:0]     in_ch,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*SW-1:0] out_data,
  output logic [CW-1:0]     out_ch,
  input  logic [CW-1:0]     cfg_out_ch,
  input  reduce_mode_e      cfg_reduce,
  input  expand_mode_e      cfg_expand
);

  typedef struct packed {
    logic [CW-1:0] cnt;
    reduce_mode_e  red;
    expand_mode_e  exp;
  } lane_cfg_t;

  lane_cfg_t live_cfg, held_cfg_q, act_cfg;
  logic      stall_q;

  assign live_cfg = '{cnt: cfg_out_ch, red: cfg_reduce, exp: cfg_expand};

  // A frame offered but not taken keeps the settings it was first converted with.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      held_cfg_q <= '0;
    end else begin
      stall_q <= in_valid & ~out_ready;
      if (!stall_q) held_cfg_q <= live_cfg;
    end
  end

  assign act_cfg = stall_q ? held_cfg_q : live_cfg;

  conv_kind_e    kind;
  logic [CW-1:0] keep;
  logic [SW-1:0] mono;
  logic [NCH*SW-1:0] exp_frame, trim_frame;

  assign kind = pick_kind(32'(in_ch), 32'(act_cfg.cnt));
  assign keep = (in_ch < act_cfg.cnt) ? in_ch : act_cfg.cnt;

  chan_reduce #(.SW(SW)) u_reduce (
    .left (in_data[0 +: SW]),
    .right(in_data[SW +: SW]),
    .mode (act_cfg.red),
    .mono (mono)
  );

  chan_expand #(.SW(SW), .NCH(NCH)) u_expand (
    .mono (in_data[0 +: SW]),
    .mode (act_cfg.exp),
    .frame(exp_frame)
  );

  chan_trim #(.SW(SW), .NCH(NCH), .CW(CW)) u_trim (
    .din (in_data),
    .keep(keep),
    .dout(trim_frame)
  );

  always_comb begin
    out_data = '0;
    case (kind)
      CONV_PASS:   out_data = in_data;
      CONV_REDUCE: out_data[0 +: SW] = mono;
      CONV_EXPAND: out_data = exp_frame;
      default:     out_data = trim_frame;
    endcase
  end

  assign out_ch    = act_cfg.cnt;
  assign out_valid = in_valid;
  assign in_ready  = out_ready;

endmodule

// File: rtl/chan_count_conv.sv
module chan_count_conv
  import chan_count_pkg::*;
#(
  parameter int  SW     = 16,
  parameter int  MAX_CH = 4,
  localparam int CW     = $clog2(MAX_CH + 1),
  localparam int DW     = MAX_CH * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pb_in_valid,
  output logic          pb_in_ready,
  input  logic [DW-1:0] pb_in_data,
  input  logic [CW-1:0] pb_in_ch,
  output logic          pb_out_valid,
  input  logic          pb_out_ready,
  output logic [DW-1:0] pb_out_data,
  output logic [CW-1:0] pb_out_ch,
  input  logic [CW-1:0] pb_cfg_out_ch,
  input  logic [1:0]    pb_cfg_reduce,
  input  logic          pb_cfg_expand,
  input  logic          cp_in_valid,
  output logic          cp_in_ready,
  input  logic [DW-1:0] cp_in_data,
  input  logic [CW-1:0] cp_in_ch,
  output logic          cp_out_valid,
  input  logic          cp_out_ready,
  output logic [DW-1:0] cp_out_data,
  output logic [CW-1:0] cp_out_ch,
  input  logic [CW-1:0] cp_cfg_out_ch,
  input  logic [1:0]    cp_cfg_reduce,
  input  logic          cp_cfg_expand
);

  // Playback: audio side in, client side out.
  chan_count_lane #(.SW(SW), .NCH(MAX_CH), .CW(CW)) u_pb (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pb_in_valid),
    .in_ready  (pb_in_ready),
    .in_data   (pb_in_data),
    .in_ch     (pb_in_ch),
    .out_valid (pb_out_valid),
    .out_ready (pb_out_ready),
    .out_data  (pb_out_data),
    .out_ch    (pb_out_ch),
    .cfg_out_ch(pb_cfg_out_ch),
    .cfg_reduce(reduce_mode_e'(pb_cfg_reduce)),
    .cfg_expand(expand_mode_e'(pb_cfg_expand))
  );

  // Capture: client side in, audio side out.
  chan_count_lane #(.SW(SW), .NCH(MAX_CH), .CW(CW)) u_cp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cp_in_valid),
    .in_ready  (cp_in_ready),
    .in_data   (cp_in_data),
    .in_ch     (cp_in_ch),
    .out_valid (cp_out_valid),
    .out_ready (cp_out_ready),
    .out_data  (cp_out_data),
    .out_ch    (cp_out_ch),
    .cfg_out_ch(cp_cfg_out_ch),
    .cfg_reduce(reduce_mode_e'(cp_cfg_reduce)),
    .cfg_expand(expand_mode_e'(cp_cfg_expand))
  );

endmodule

// File: rtl/chan_count_conv_chk.sv
module chan_count_conv_chk #(
  parameter int SW     = 16,
  parameter int MAX_CH = 4,
  parameter int CW     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pb_in_valid,
  input logic                 pb_in_ready,
  input logic [MAX_CH*SW-1:0] pb_in_data,
  input logic [CW-1:0]        pb_in_ch,
  input logic                 pb_out_valid,
  input logic                 pb_out_ready,
  input logic [MAX_CH*SW-1:0] pb_out_data,
  input logic [CW-1:0]        pb_out_ch,
  input logic [CW-1:0]        pb_cfg_out_ch,
  input logic                 cp_in_valid,
  input logic                 cp_in_ready,
  input logic [MAX_CH*SW-1:0] cp_in_data,
  input logic [CW-1:0]        cp_in_ch,
  input logic                 cp_out_valid,
  input logic                 cp_out_ready,
  input logic [MAX_CH*SW-1:0] cp_out_data,
  input logic [CW-1:0]        cp_out_ch
);

  a_r1_pb_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pb_out_valid == pb_in_valid);
  a_r1_pb_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pb_in_ready == pb_out_ready);
  a_r1_cp_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cp_out_valid == cp_in_valid);
  a_r1_cp_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cp_in_ready == cp_out_ready);

  a_r2_pb_mono_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_out_valid && pb_out_ch == CW'(1) && pb_in_ch >= CW'(2))
      |-> pb_out_data[MAX_CH*SW-1:SW] == '0);

  a_r5_pb_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_out_valid && pb_out_ch == pb_in_ch) |-> pb_out_data == pb_in_data);
  a_r5_cp_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_out_valid && cp_out_ch == cp_in_ch) |-> cp_out_data == cp_in_data);

  a_r8_pb_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(pb_out_valid && !pb_out_ready) && pb_in_valid &&
     $stable(pb_in_data) && $stable(pb_in_ch))
      |-> ($stable(pb_out_data) && $stable(pb_out_ch)));
  a_r8_cp_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cp_out_valid && !cp_out_ready) && cp_in_valid &&
     $stable(cp_in_data) && $stable(cp_in_ch))
      |-> ($stable(cp_out_data) && $stable(cp_out_ch)));

  a_r9_pb_count_live: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_in_valid && $past(rst_n) && !$past(pb_out_valid && !pb_out_ready))
      |-> pb_out_ch == pb_cfg_out_ch);

endmodule

bind chan_count_conv chan_count_conv_chk #(.SW(SW), .MAX_CH(MAX_CH), .CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pb_in_valid  (pb_in_valid),
  .pb_in_ready  (pb_in_ready),
  .pb_in_data   (pb_in_data),
  .pb_in_ch     (pb_in_ch),
  .pb_out_valid (pb_out_valid),
  .pb_out_ready (pb_out_ready),
  .pb_out_data  (pb_out_data),
  .pb_out_ch    (pb_out_ch),
  .pb_cfg_out_ch(pb_cfg_out_ch),
  .cp_in_valid  (cp_in_valid),
  .cp_in_ready  (cp_in_ready),
  .cp_in_data   (cp_in_data),
  .cp_in_ch     (cp_in_ch),
  .cp_out_valid (cp_out_valid),
  .cp_out_ready (cp_out_ready),
  .cp_out_data  (cp_out_data),
  .cp_out_ch    (cp_out_ch)
);

// File: tb/chan_count_conv_tb_top.sv
`timescale 1ns/1ps
module chan_count_conv_tb_top;

  localparam int SW = 4;
  localparam int NC = 4;
  localparam int DW = SW * NC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          pb_in_valid = 0, pb_out_ready = 1, pb_cfg_expand = 0;
  logic          cp_in_valid = 0, cp_out_ready = 1, cp_cfg_expand = 0;
  logic [DW-1:0] pb_in_data = '0, cp_in_data = '0;
  logic [2:0]    pb_in_ch = 3'd2, cp_in_ch = 3'd2, pb_cfg_out_ch = 3'd2, cp_cfg_out_ch = 3'd2;
  logic [1:0]    pb_cfg_reduce = 0, cp_cfg_reduce = 0;
  logic          pb_in_ready, pb_out_valid, cp_in_ready, cp_out_valid;
  logic [DW-1:0] pb_out_data, cp_out_data;
  logic [2:0]    pb_out_ch, cp_out_ch;

  chan_count_conv #(.SW(SW), .MAX_CH(NC)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pb_in_valid(pb_in_valid), .pb_in_ready(pb_in_ready), .pb_in_data(pb_in_data),
    .pb_in_ch(pb_in_ch), .pb_out_valid(pb_out_valid), .pb_out_ready(pb_out_ready),
    .pb_out_data(pb_out_data), .pb_out_ch(pb_out_ch), .pb_cfg_out_ch(pb_cfg_out_ch),
    .pb_cfg_reduce(pb_cfg_reduce), .pb_cfg_expand(pb_cfg_expand),
    .cp_in_valid(cp_in_valid), .cp_in_ready(cp_in_ready), .cp_in_data(cp_in_data),
    .cp_in_ch(cp_in_ch), .cp_out_valid(cp_out_valid), .cp_out_ready(cp_out_ready),
    .cp_out_data(cp_out_data), .cp_out_ch(cp_out_ch), .cp_cfg_out_ch(cp_cfg_out_ch),
    .cp_cfg_reduce(cp_cfg_reduce), .cp_cfg_expand(cp_cfg_expand)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int smp(input logic [DW-1:0] d, input int k);
    logic [SW-1:0] v;
    v = d[k*SW +: SW];
    return (v[SW-1]) ? int'(v) - (1 << SW) : int'(v);
  endfunction

  // Expected frame from the stated conversion rules.
  function automatic logic [DW-1:0] expect_frame(input logic [DW-1:0] d, input int in_n,
      input int out_n, input int red, input int ex);
    logic [DW-1:0] r;
    int sum, v, lim;
    r = '0;
    if (in_n == out_n) return d;
    if (out_n == 1 && in_n >= 2) begin
      if (red == 1) v = smp(d, 1);
      else if (red == 2) begin
        sum = smp(d, 0) + smp(d, 1);
        v = (sum >= 0) ? sum / 2 : -((1 - sum) / 2);
      end else v = smp(d, 0);
      r[SW-1:0] = v[SW-1:0];
      return r;
    end
    if (in_n == 1) begin
      r[0 +: SW] = d[0 +: SW];
      if (ex == 1) r[SW +: SW] = d[0 +: SW];
      return r;
    end
    lim = (in_n < out_n) ? in_n : out_n;
    for (int k = 0; k < lim; k++) r[k*SW +: SW] = d[k*SW +: SW];
    return r;
  endfunction

  // Present one frame on a direction at the falling edge and check it 1 ns later.
  task automatic frame(input bit dir, input logic [DW-1:0] d, input int in_n, input int out_n,
      input int red, input int ex, input string req);
    @(negedge clk);
    if (!dir) begin
      pb_in_valid = 1; pb_in_data = d; pb_in_ch = 3'(in_n); pb_cfg_out_ch = 3'(out_n);
      pb_cfg_reduce = 2'(red); pb_cfg_expand = 1'(ex);
    end else begin
      cp_in_valid = 1; cp_in_data = d; cp_in_ch = 3'(in_n); cp_cfg_out_ch = 3'(out_n);
      cp_cfg_reduce = 2'(red); cp_cfg_expand = 1'(ex);
    end
    #1;
    if (!dir) begin
      check(req, 32'(pb_out_data), 32'(expect_frame(d, in_n, out_n, red, ex)));
    end else begin
      check(req, 32'(cp_out_data), 32'(expect_frame(d, in_n, out_n, red, ex)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state and handshake pass-through
    check("R1 pb_out_valid after reset", 32'(pb_out_valid), 0);
    check("R1 cp_out_valid after reset", 32'(cp_out_valid), 0);
    check("R1 pb_in_ready", 32'(pb_in_ready), 1);
    pb_out_ready = 0; cp_out_ready = 0; #0.5;
    check("R1 pb_in_ready follows out_ready", 32'(pb_in_ready), 0);
    check("R1 cp_in_ready follows out_ready", 32'(cp_in_ready), 0);
    pb_out_ready = 1; cp_out_ready = 1;

    // R2 / R3: every sample pair in every reduction mode, both directions
    for (int dir = 0; dir < 2; dir++)
      for (int red = 0; red < 4; red++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            frame(dir[0], DW'({4'h9, 4'h6, 4'(b), 4'(a)}), 2, 1, red, 1,
                  (red == 2) ? "R3 average" : "R2 reduce");
            if (dir == 0) begin
              check("R1 pb_out_valid", 32'(pb_out_valid), 1);
              check("R9 pb_out_ch", 32'(pb_out_ch), 1);
            end else check("R9 cp_out_ch", 32'(cp_out_ch), 1);
          end
    // R2 with more than two input channels
    for (int n = 3; n <= 4; n++)
      for (int red = 0; red < 4; red++)
        frame(0, 16'hA5C3, n, 1, red, 0, "R2 reduce multi-channel");

    // R4: expansion to 2, 3 and 4 channels
    for (int dir = 0; dir < 2; dir++)
      for (int ex = 0; ex < 2; ex++)
        for (int m = 2; m <= 4; m++)
          for (int v = 0; v < 16; v++)
            frame(dir[0], DW'({12'hBEE, 4'(v)}), 1, m, 3 - ex, ex, "R4 expand");

    // R5: equal counts pass through under every mode
    for (int dir = 0; dir < 2; dir++)
      for (int n = 1; n <= 4; n++)
        for (int red = 0; red < 4; red++)
          for (int ex = 0; ex < 2; ex++)
            frame(dir[0], DW'(16'h1F2E ^ (n * 16'h0731) ^ (red << 5)), n, n, red, ex, "R5 pass");

    // R6: remaining count pairs keep leading channels
    for (int dir = 0; dir < 2; dir++)
      for (int i = 2; i <= 4; i++)
        for (int o = 2; o <= 4; o++)
          if (i != o) frame(dir[0], 16'h8C47, i, o, 2, 1, "R6 trim");

    // R7: both directions at once with different settings
    @(negedge clk);
    pb_in_data = 16'h0073; pb_in_ch = 2; pb_cfg_out_ch = 1; pb_cfg_reduce = 2;
    cp_in_data = 16'h0073; cp_in_ch = 2; cp_cfg_out_ch = 1; cp_cfg_reduce = 1;
    #1;
    check("R7 pb uses its own mode", 32'(pb_out_data), 32'(expect_frame(16'h0073, 2, 1, 2, 0)));
    check("R7 cp uses its own mode", 32'(cp_out_data), 32'(expect_frame(16'h0073, 2, 1, 1, 0)));
    cp_cfg_out_ch = 3;
    #0.5;
    check("R7 cp count leaves pb", 32'(pb_out_ch), 1);

    // R8: settings frozen during a stall, released after the handshake
    for (int dir = 0; dir < 2; dir++) begin
      @(negedge clk);
      if (dir == 0) begin
        pb_in_data = 16'h00D5; pb_in_ch = 2; pb_cfg_out_ch = 1; pb_cfg_reduce = 2; pb_out_ready = 0;
      end else begin
        cp_in_data = 16'h00D5; cp_in_ch = 2; cp_cfg_out_ch = 1; cp_cfg_reduce = 2; cp_out_ready = 0;
      end
      @(negedge clk);
      if (dir == 0) begin pb_cfg_reduce = 0; pb_cfg_out_ch = 2; end
      else begin cp_cfg_reduce = 0; cp_cfg_out_ch = 2; end
      #1;
      check("R8 data held in stall", 32'(dir ? cp_out_data : pb_out_data),
            32'(expect_frame(16'h00D5, 2, 1, 2, 0)));
      check("R8 count held in stall", 32'(dir ? cp_out_ch : pb_out_ch), 1);
      if (dir == 0) pb_out_ready = 1; else cp_out_ready = 1;
      @(negedge clk);
      if (dir == 0) pb_cfg_out_ch = 1; else cp_cfg_out_ch = 1;
      #1;
      check("R8 new mode after handshake", 32'(dir ? cp_out_data : pb_out_data),
            32'(expect_frame(16'h00D5, 2, 1, 0, 0)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule